// File: doc/BRIEF.md
# Frame-Synced Serial DAC Front End

This block is the digital receive side of a 12-bit serial-input digital-to-analog converter. A host sends one 16-bit word per frame over four pins: an active-low select, a frame-sync strobe, a serial clock and a data line. The block assembles the word and moves it into a 12-bit code register and two control flags. One flag picks fast or slow settling. The other commands power-down. A single-cycle strobe marks each load.

Every pin is sampled by a fast system clock that runs at least four times the serial clock rate. Each pin passes through a two-flop synchronizer, and its edges are found in the system clock domain. A frame opens on a falling edge of the frame-sync pin. It closes on the serial clock rising edge that follows the sixteenth falling edge, or earlier if frame-sync goes high first. The block works with a per-device select line (four-wire use) and also with the select pin tied low (three-wire use), where frame-sync alone marks the word.

Top module: `sdac_frontend`

## Requirements
- R1: After reset, `dac_code` is 0, `fast_mode` and `power_down` are 0, and `update` is low.
- R2: While `cs_n` is high, edges on `sclk`, `fs` and `din` change no output. A rise of `cs_n` in the middle of a frame abandons it, with no `update` and no change to the outputs.
- R3: A falling edge of `fs` while `cs_n` is low opens a new frame and clears the bit count and the shift register.
- R4: `din` is captured on each falling edge of `sclk`, most significant bit first. Word bits 11..0 become `dac_code`.
- R5: Word bit 14 drives `fast_mode` (1 = fast). Word bit 13 drives `power_down` (1 = powered down). Word bits 15 and 12 have no effect.
- R6: The `sclk` rising edge that follows the sixteenth falling edge loads the word. `update` is high for exactly one clock per loaded frame.
- R7: A rise of `fs` before the sixteenth bit loads the bits received so far. They sit right-aligned in the word, with zeros above them.
- R8: Falling `sclk` edges after the sixteenth in a frame are ignored, and the frame makes no second load, until the next falling edge of `fs`.
- R9: Between loads, `dac_code`, `fast_mode` and `power_down` hold their values.
- R10: With `cs_n` held low at all times, frames are delimited by `fs` alone and load correctly.
- R11: A word sent as two 8-bit bursts, with `fs` held low through the pause between them, loads the same value as one continuous burst.
- R12: When a rise of `fs` and a falling `sclk` edge reach the block in the same cycle, that bit is captured and is part of the loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; at least 4x the serial clock rate |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Device select, active low |
| fs | input | 1 | Frame sync; a falling edge opens a frame |
| sclk | input | 1 | Serial bit clock |
| din | input | 1 | Serial data, captured on falling `sclk` |
| dac_code | output | 12 | Latched converter code |
| fast_mode | output | 1 | Settling speed flag, 1 = fast |
| power_down | output | 1 | Power-down flag, 1 = powered down |
| update | output | 1 | One-cycle strobe on each load |

## Verification
Two events can reach the frame logic in the same system clock cycle: the early-termination rise of `fs` and a falling `sclk` edge, or, on the sixteenth bit, that rise and the final capture. The bench provokes this by changing `fs` and `sclk` at the same instant. Both signals pass through synchronizers of equal depth, so the two edges are detected in one cycle. The bench then requires a single `update` pulse and a loaded word that includes the coincident bit. A separate case lets the normal sixteenth-bit load happen and then brings `fs` high later, and checks that no second load follows.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Default geometry of a serial word and the code it carries.
  localparam int WORD_W_DEF = 16;
  localparam int CODE_W_DEF = 12;
  localparam int SYNC_DEF   = 2;

  // Control flags pulled from the upper nibble of a word.
  typedef struct packed {
    logic fast;
    logic pdown;
  } sdac_ctrl_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          N       = 4,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              fs_s,
  input  logic              sclk_s,
  input  logic              din_s,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              sclk_q, fs_q;
  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;

  logic sel, sclk_fall, sclk_rise, fs_fall, fs_rise;
  logic take_bit, end_full, end_early;
  logic [WORD_W-1:0] sh_next;

  always_comb begin
    sel       = ~cs_n_s;
    sclk_fall = sclk_q & ~sclk_s;
    sclk_rise = ~sclk_q & sclk_s;
    fs_fall   = fs_q & ~fs_s;
    fs_rise   = ~fs_q & fs_s;
    take_bit  = sel & active & ~fs_fall & sclk_fall & (cnt < FULL);
    sh_next   = take_bit ? {shreg[WORD_W-2:0], din_s} : shreg;
    end_full  = sel & active & ~fs_fall & (cnt == FULL) & sclk_rise;
    end_early = sel & active & ~fs_fall & fs_rise;
    commit    = end_full | end_early;
    word      = sh_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b1;
      fs_q   <= 1'b1;
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else begin
      sclk_q <= sclk_s;
      fs_q   <= fs_s;
      if (!sel) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (fs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
        shreg  <= '0;
      end else if (active) begin
        shreg <= sh_next;
        if (take_bit) cnt <= cnt + 1'b1;
        if (commit) active <= 1'b0;
      end
    end
  end

  // R2: a deselected interface leaves no frame open
  a_r2_deselect_closes: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !active);
  // R3: frame start clears the count
  a_r3_frame_open: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_s && fs_q && !fs_s) |=> (active && cnt == '0 && shreg == '0));
  // R8: a full register ignores further falling edges
  a_r8_full_frozen: assert property (@(posedge clk) disable iff (rst)
    (cnt == FULL && sclk_q && !sclk_s && !(fs_q && !fs_s)) |=> $stable(shreg));
  // R6: never more than one word's worth of bits
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
  import sdac_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] code,
  output sdac_ctrl_t        ctrl,
  output logic              update
);
  localparam int SPEED_POS = WORD_W - 2;
  localparam int PD_POS    = WORD_W - 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= '0;
      ctrl   <= '0;
      update <= 1'b0;
    end else begin
      update <= commit;
      if (commit) begin
        code       <= word[CODE_W-1:0];
        ctrl.fast  <= word[SPEED_POS];
        ctrl.pdown <= word[PD_POS];
      end
    end
  end

  // R9: outputs hold without a load
  a_r9_hold_code: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(code) && $stable(ctrl)));
  // R6: the strobe lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    update |=> !update);
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF,
  parameter int CODE_W = CODE_W_DEF,
  parameter int SYNC_N = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              fs,
  input  logic              sclk,
  input  logic              din,
  output logic [CODE_W-1:0] dac_code,
  output logic              fast_mode,
  output logic              power_down,
  output logic              update
);
  logic [3:0]        pins_s;
  logic              commit;
  logic [WORD_W-1:0] word;
  sdac_ctrl_t        ctrl;

  // Idle levels: select, frame sync and clock high, data low.
  sdac_sync #(.N(4), .STAGES(SYNC_N), .RST_VAL(4'b1110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, fs, sclk, din}),
    .q   (pins_s)
  );

  sdac_frame #(.WORD_W(WORD_W)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .cs_n_s (pins_s[3]),
    .fs_s   (pins_s[2]),
    .sclk_s (pins_s[1]),
    .din_s  (pins_s[0]),
    .commit (commit),
    .word   (word)
  );

  sdac_latch #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .commit (commit),
    .word   (word),
    .code   (dac_code),
    .ctrl   (ctrl),
    .update (update)
  );

  assign fast_mode  = ctrl.fast;
  assign power_down = ctrl.pdown;
endmodule

// File: tb/test_sdac_frontend.sv
module test_sdac_frontend;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, fs = 1'b1, sclk = 1'b1, din = 1'b0;
  logic [11:0] dac_code;
  logic fast_mode, power_down, update;

  int n_tests = 0, n_fail = 0, upd_cnt = 0, upd_base = 0;
  logic [11:0] m_code = '0;
  logic m_fast = 1'b0, m_pd = 1'b0;
  bit done = 1'b0;

  sdac_frontend i_sdac_frontend (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fs(fs), .sclk(sclk), .din(din),
    .dac_code(dac_code), .fast_mode(fast_mode), .power_down(power_down),
    .update(update)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (!rst && update) upd_cnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected effect of loading the first n bits of w (R4, R5, R7).
  task automatic expect_word(input logic [15:0] w, input int n);
    logic [15:0] v;
    v = w >> (16 - n);
    m_code = v[11:0];
    m_fast = v[14];
    m_pd   = v[13];
  endtask

  task automatic shift_bits(input logic [15:0] w, input int from, input int to);
    for (int i = from; i < to; i++) begin
      din = w[15-i];
      tick(HALF);
      sclk = 1'b0;
      tick(HALF);
      sclk = 1'b1;
    end
  endtask

  task automatic check(input string req, input int exp_pulses);
    tick(10);
    n_tests++;
    if (dac_code !== m_code || fast_mode !== m_fast || power_down !== m_pd) begin
      n_fail++;
      $display("FAIL %s: code=%h fast=%b pd=%b, expected code=%h fast=%b pd=%b",
               req, dac_code, fast_mode, power_down, m_code, m_fast, m_pd);
    end
    n_tests++;
    if (upd_cnt - upd_base != exp_pulses) begin
      n_fail++;
      $display("FAIL %s: update pulses=%0d, expected %0d", req, upd_cnt - upd_base, exp_pulses);
    end
  endtask

  task automatic full_frame(input logic [15:0] w, input bit three_wire, input string req);
    upd_base = upd_cnt;
    cs_n = 1'b0;
    tick(2);
    fs = 1'b0;
    tick(HALF);
    shift_bits(w, 0, 16);
    tick(HALF);
    fs = 1'b1;
    tick(HALF);
    if (!three_wire) cs_n = 1'b1;
    expect_word(w, 16);
    check(req, 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'h5eed1234));
    tick(4);
    rst = 1'b0;
    tick(3);
    // R1: reset state
    n_tests++;
    if (dac_code !== 12'h000 || fast_mode !== 1'b0 || power_down !== 1'b0 || update !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: code=%h fast=%b pd=%b upd=%b, expected all zero",
               dac_code, fast_mode, power_down, update);
    end

    // R4 R6: plain four-wire frame
    full_frame(16'h0A5C, 1'b0, "R4 R6 four-wire word");
    // R5: bit 14 fast, bit 13 power-down
    full_frame(16'h6123, 1'b0, "R5 both flags set");
    // R5: bits 15 and 12 ignored
    full_frame(16'h9FFF, 1'b0, "R5 reserved bits ignored");

    // R2: everything ignored while deselected
    upd_base = upd_cnt;
    cs_n = 1'b1;
    fs = 1'b0;
    tick(HALF);
    shift_bits(16'h7777, 0, 16);
    fs = 1'b1;
    check("R2 deselected frame ignored", 0);

    // R2: select rising mid-frame aborts (R9: outputs hold)
    upd_base = upd_cnt;
    cs_n = 1'b0;
    tick(2);
    fs = 1'b0;
    tick(HALF);
    shift_bits(16'h4321, 0, 8);
    cs_n = 1'b1;
    tick(HALF);
    fs = 1'b1;
    check("R2 R9 abort on select rise", 0);

    // R7: early frame end after 10 bits
    upd_base = upd_cnt;
    cs_n = 1'b0;
    tick(2);
    fs = 1'b0;
    tick(HALF);
    shift_bits(16'hE6B5, 0, 10);
    tick(HALF);
    fs = 1'b1;
    tick(HALF);
    cs_n = 1'b1;
    expect_word(16'hE6B5, 10);
    check("R7 partial frame", 1);

    // R3: a new frame start clears leftover bits; early end after 3 bits
    upd_base = upd_cnt;
    cs_n = 1'b0;
    tick(2);
    fs = 1'b0;
    tick(HALF);
    shift_bits(16'hFFFF, 0, 6);
    fs = 1'b1;
    tick(HALF);
    expect_word(16'hFFFF, 6);
    upd_base = upd_cnt - 1;
    fs = 1'b0;
    tick(HALF);
    shift_bits(16'hA000, 0, 3);
    tick(HALF);
    fs = 1'b1;
    tick(HALF);
    cs_n = 1'b1;
    expect_word(16'hA000, 3);
    check("R3 frame restart clears register", 2);

    // R8: extra falling edges after the sixteenth are ignored
    upd_base = upd_cnt;
    cs_n = 1'b0;
    tick(2);
    fs = 1'b0;
    tick(HALF);
    shift_bits(16'h2BCD, 0, 16);
    shift_bits(16'hFFFF, 0, 5);
    tick(HALF);
    fs = 1'b1;
    tick(HALF);
    cs_n = 1'b1;
    expect_word(16'h2BCD, 16);
    check("R8 extra clocks ignored", 1);

    // R11: two bytes with a pause, frame sync held low
    upd_base = upd_cnt;
    cs_n = 1'b0;
    tick(2);
    fs = 1'b0;
    tick(HALF);
    shift_bits(16'h4E71, 0, 8);
    tick(40);
    shift_bits(16'h4E71, 8, 16);
    tick(HALF);
    fs = 1'b1;
    tick(HALF);
    cs_n = 1'b1;
    expect_word(16'h4E71, 16);
    check("R11 two-byte word", 1);

    // R12: frame sync rise coincident with the sixteenth falling edge
    upd_base = upd_cnt;
    cs_n = 1'b0;
    tick(2);
    fs = 1'b0;
    tick(HALF);
    shift_bits(16'h5A3B, 0, 15);
    din = 1'b1;
    tick(HALF);
    sclk = 1'b0;
    fs = 1'b1;
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
    cs_n = 1'b1;
    expect_word(16'h5A3B, 16);
    check("R12 coincident edge bit kept", 1);

    // R12: coincident with a mid-frame falling edge (9th bit)
    upd_base = upd_cnt;
    cs_n = 1'b0;
    tick(2);
    fs = 1'b0;
    tick(HALF);
    shift_bits(16'hC3C3, 0, 8);
    din = 1'b1;
    tick(HALF);
    sclk = 1'b0;
    fs = 1'b1;
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
    cs_n = 1'b1;
    expect_word(16'hC3C3, 9);
    check("R12 coincident mid-frame bit kept", 1);

    // R10: three-wire, select held low through several frames
    cs_n = 1'b0;
    full_frame(16'h5FFF, 1'b1, "R10 three-wire first");
    full_frame(16'h0001, 1'b1, "R10 three-wire second");

    // Random words in both wirings (R4 R5 R6 R10)
    for (int k = 0; k < 24; k++) begin
      w = 16'($urandom);
      full_frame(w, 1'($urandom % 2), "R4 R5 R6 random word");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule